// File: doc/BRIEF.md
# ADC Trigger Chain Sequencer

This block turns trigger events into ordered series of conversion commands for an analog-to-digital converter. There are eight trigger groups. Each group can take its trigger from a hardware input or from a software pulse. For each group the block holds a priority, a chain length, a start delay and a spacing between steps. Each step of a chain names a converter command slot (one-hot), an input channel and an optional completion flag. When triggers are waiting, the block picks the one with the highest priority. It waits out the start delay, then issues the steps one at a time on a request/complete handshake. Between steps it either waits a programmed interval or moves straight on in back-to-back mode.

Every result that comes back is stored against its group and step, and a read port returns it. The block sets completion flags per group as each step finishes and sets a transfer request flag per group when a whole chain ends. It sets an error flag when a trigger arrives for a group that is already queued or running. A system integrator drives the configuration vectors from a register file and connects the handshake to the converter's command interface.

Top module: `adc_seq_top`

## Requirements
- R1: With `sw_mode[g]`=0, a rising edge on `hw_trig[g]` queues group g, and `sw_trig[g]` is ignored. With `sw_mode[g]`=1, a high `sw_trig[g]` in a cycle queues group g, and `hw_trig[g]` is ignored. A level held high queues the group only once.
- R2: `grp_prio[g*3+:3]` sets group g's priority, where 7 is the highest and 0 the lowest. When priorities are equal, the lower group index wins. A new group is chosen only when no chain is active, and a running chain is never preempted.
- R3: `grp_len[g*3+:3]` holds the chain length minus one, so 0 issues one step and 7 issues eight.
- R4: Delays are counted in ticks. A tick occurs once every `prescale`+1 clock cycles. For a trigger sampled at clock edge t with start delay N, `conv_req` first rises after edge t+2+N*(`prescale`+1).
- R5: With `grp_b2b[g]`=0, the next step's request rises after edge a+1+I*(`prescale`+1), where a is the completion edge and I is `grp_intv`. With `grp_b2b[g]`=1, the request rises after edge a+1 and is low for exactly one cycle.
- R6: During step s of group g, `conv_slot` equals `seg_slot[(g*8+s)*8+:8]` and `conv_chan` equals `seg_chan[(g*8+s)*5+:5]`. `conv_req` stays high with stable fields until `conv_ack` arrives.
- R7: The `conv_result` present with `conv_ack` is stored for that group and step. Setting `rd_grp` and `rd_seg` returns it on `rd_data`, and the value is 0 after reset.
- R8: When a step completes, its 2-bit code `seg_irq[(g*8+s)*2+:2]` sets a flag: 1 sets `done_flags[g*3+0]`, 2 sets `done_flags[g*3+1]`, 3 sets `done_flags[g*3+2]`, and 0 sets nothing. `stat_clr[g]` clears group g's done and error flags.
- R9: When the last step of a chain completes, `dma_req[g]` is set, but only if `dma_en[g]` is 1. Writing 1 to `dma_clr[g]` clears it.
- R10: A trigger for a group that is queued or running sets `err_flags[g]`, and no extra chain runs.
- R11: While `soft_rst` is 1, all sequencing state, flags and stored results are held at reset and triggers are ignored.
- R12: After `rst`, `conv_req` is 0 and all flags and stored results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Holds sequencing logic in reset while high |
| hw_trig | input | 8 | Hardware trigger per group (edge) |
| sw_trig | input | 8 | Software trigger pulse per group |
| sw_mode | input | 8 | 1 = software source for the group |
| grp_prio | input | 24 | 3-bit priority per group |
| grp_len | input | 24 | 3-bit chain length minus one per group |
| grp_init_dly | input | 64 | 8-bit start delay per group, in ticks |
| grp_intv | input | 64 | 8-bit step interval per group, in ticks |
| grp_b2b | input | 8 | Back-to-back step enable per group |
| prescale | input | 8 | Tick divider minus one |
| seg_slot | input | 512 | One-hot command slot per group and step |
| seg_chan | input | 320 | Channel number per group and step |
| seg_irq | input | 128 | Completion flag code per group and step |
| dma_en | input | 8 | Transfer request enable per group |
| dma_clr | input | 8 | Write-1 clear of transfer requests |
| stat_clr | input | 8 | Write-1 clear of a group's done and error flags |
| conv_req | output | 1 | Conversion request |
| conv_slot | output | 8 | Command slot of the current request |
| conv_chan | output | 5 | Channel of the current request |
| conv_ack | input | 1 | Conversion complete pulse |
| conv_result | input | 12 | Result present with conv_ack |
| rd_grp | input | 3 | Result read group |
| rd_seg | input | 3 | Result read step |
| rd_data | output | 12 | Stored result for rd_grp and rd_seg |
| done_flags | output | 24 | Three done flags per group |
| err_flags | output | 8 | Trigger collision flag per group |
| dma_req | output | 8 | Transfer request flag per group |

## Verification
Some properties are checked on every cycle. An outstanding request keeps its slot and channel until completion, the active group never changes while a chain runs, and done and transfer flags only rise on a completion. The tick spacing of the delay timer and the queuing of an accepted trigger are also checked continuously. Other behaviour only shows up in the bench's scenarios: the exact cycle counts of start delays and intervals, the order among several queued groups, the stored result per step, the flag values after a chain, and the effect of soft reset. Each of these needs a chosen configuration and an expected value worked out from it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_INIT = 2'd1,
        SQ_REQ  = 2'd2,
        SQ_GAP  = 2'd3
    } seq_state_e;

    localparam int PRIO_W   = 3;
    localparam int IRQ_W    = 2;
    localparam int NUM_DONE = 3;

    // map a step's flag code to the group's three done bits
    function automatic logic [NUM_DONE-1:0] done_decode(input logic [IRQ_W-1:0] code);
        case (code)
            2'd1:    return 3'b001;
            2'd2:    return 3'b010;
            2'd3:    return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int NG = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NG-1:0] hw_trig,
    input  logic [NG-1:0] sw_trig,
    input  logic [NG-1:0] sw_mode,
    input  logic [NG-1:0] run_mask,
    input  logic [NG-1:0] take,
    output logic [NG-1:0] pend,
    output logic [NG-1:0] err_evt
);
    logic [NG-1:0] hw_q;
    logic [NG-1:0] evt;

    always_comb begin
        evt     = (sw_mode & sw_trig) | (~sw_mode & hw_trig & ~hw_q);
        err_evt = evt & (pend | run_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q <= '0;
            pend <= '0;
        end else begin
            hw_q <= hw_trig;
            pend <= (pend & ~take) | (evt & ~err_evt);
        end
    end

    generate
        for (genvar g = 0; g < NG; g++) begin : g_chk
            AST_TRIG_QUEUED: assert property (@(posedge clk) disable iff (rst)
                (evt[g] && !pend[g] && !run_mask[g]) |=> pend[g]); // R1
        end
    endgenerate
endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
    parameter int NG = 8
) (
    input  logic [NG-1:0]                      pend,
    input  logic [NG*adc_seq_pkg::PRIO_W-1:0]  prio,
    output logic                               hit,
    output logic [$clog2(NG)-1:0]              idx
);
    import adc_seq_pkg::*;

    logic [PRIO_W-1:0] best;

    // walk downward so an equal priority at a lower index replaces the pick
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (pend[g] && (!hit || prio[g*PRIO_W +: PRIO_W] >= best)) begin
                hit  = 1'b1;
                idx  = ($clog2(NG))'(g);
                best = prio[g*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int DW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic [PW-1:0] prescale,
    output logic          zero
);
    logic [PW-1:0] pcnt;
    logic [DW-1:0] cnt;
    logic          tick;

    always_comb begin
        tick = (pcnt == prescale);
        zero = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (load) begin
            pcnt <= '0;
            cnt  <= load_val;
        end else begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
            if (tick && !zero) cnt <= cnt - 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && prescale != '0) |=> (!tick || prescale == '0)); // R4
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int NG    = 8,
    parameter int NSEG  = 8,
    parameter int NSLOT = 8,
    parameter int CW    = 5,
    parameter int RW    = 12,
    parameter int DW    = 8,
    parameter int PW    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           soft_rst,
    input  logic [NG-1:0]                  hw_trig,
    input  logic [NG-1:0]                  sw_trig,
    input  logic [NG-1:0]                  sw_mode,
    input  logic [NG*3-1:0]                grp_prio,
    input  logic [NG*$clog2(NSEG)-1:0]     grp_len,
    input  logic [NG*DW-1:0]               grp_init_dly,
    input  logic [NG*DW-1:0]               grp_intv,
    input  logic [NG-1:0]                  grp_b2b,
    input  logic [PW-1:0]                  prescale,
    input  logic [NG*NSEG*NSLOT-1:0]       seg_slot,
    input  logic [NG*NSEG*CW-1:0]          seg_chan,
    input  logic [NG*NSEG*2-1:0]           seg_irq,
    input  logic [NG-1:0]                  dma_en,
    input  logic [NG-1:0]                  dma_clr,
    input  logic [NG-1:0]                  stat_clr,
    output logic                           conv_req,
    output logic [NSLOT-1:0]               conv_slot,
    output logic [CW-1:0]                  conv_chan,
    input  logic                           conv_ack,
    input  logic [RW-1:0]                  conv_result,
    input  logic [$clog2(NG)-1:0]          rd_grp,
    input  logic [$clog2(NSEG)-1:0]        rd_seg,
    output logic [RW-1:0]                  rd_data,
    output logic [NG*3-1:0]                done_flags,
    output logic [NG-1:0]                  err_flags,
    output logic [NG-1:0]                  dma_req
);
    import adc_seq_pkg::*;

    localparam int GIW = $clog2(NG);
    localparam int SIW = $clog2(NSEG);

    logic                 r;
    seq_state_e           state;
    logic [GIW-1:0]       cur_grp;
    logic [SIW-1:0]       seg;
    logic [RW-1:0]        res_q [NG][NSEG];
    logic [NG-1:0]        pend, err_evt, take, run_mask;
    logic                 pick_hit;
    logic [GIW-1:0]       pick_idx;
    logic                 last, fin, tmr_load, tmr_zero;
    logic [DW-1:0]        tmr_val;
    logic [NG*3-1:0]      done_set, done_clr;
    logic [NG-1:0]        dma_set;
    int                   sidx;

    assign r = rst | soft_rst;

    adc_seq_trig #(.NG(NG)) u_trig (
        .clk(clk), .rst(r), .hw_trig(hw_trig), .sw_trig(sw_trig),
        .sw_mode(sw_mode), .run_mask(run_mask), .take(take),
        .pend(pend), .err_evt(err_evt)
    );

    adc_seq_arb #(.NG(NG)) u_arb (
        .pend(pend), .prio(grp_prio), .hit(pick_hit), .idx(pick_idx)
    );

    adc_seq_timer #(.DW(DW), .PW(PW)) u_tmr (
        .clk(clk), .rst(r), .load(tmr_load), .load_val(tmr_val),
        .prescale(prescale), .zero(tmr_zero)
    );

    always_comb begin
        sidx      = int'(cur_grp) * NSEG + int'(seg);
        conv_req  = (state == SQ_REQ);
        conv_slot = seg_slot[sidx*NSLOT +: NSLOT];
        conv_chan = seg_chan[sidx*CW +: CW];
        last      = (seg == grp_len[int'(cur_grp)*SIW +: SIW]);
        fin       = conv_req && conv_ack;
        run_mask  = '0;
        if (state != SQ_IDLE) run_mask[cur_grp] = 1'b1;
        take      = '0;
        if (state == SQ_IDLE && pick_hit) take[pick_idx] = 1'b1;
        tmr_load  = (state == SQ_IDLE && pick_hit) || (fin && !last);
        if (state == SQ_IDLE)
            tmr_val = grp_init_dly[int'(pick_idx)*DW +: DW];
        else
            tmr_val = grp_b2b[cur_grp] ? '0 : grp_intv[int'(cur_grp)*DW +: DW];
        done_set  = '0;
        dma_set   = '0;
        if (fin) begin
            done_set[int'(cur_grp)*3 +: 3] = done_decode(seg_irq[sidx*IRQ_W +: IRQ_W]);
            if (last) dma_set[cur_grp] = dma_en[cur_grp];
        end
        for (int g = 0; g < NG; g++) done_clr[g*3 +: 3] = {3{stat_clr[g]}};
        rd_data   = res_q[rd_grp][rd_seg];
    end

    always_ff @(posedge clk) begin
        if (r) begin
            state      <= SQ_IDLE;
            cur_grp    <= '0;
            seg        <= '0;
            done_flags <= '0;
            err_flags  <= '0;
            dma_req    <= '0;
            for (int g = 0; g < NG; g++)
                for (int s = 0; s < NSEG; s++) res_q[g][s] <= '0;
        end else begin
            done_flags <= (done_flags & ~done_clr) | done_set;
            err_flags  <= (err_flags & ~stat_clr) | err_evt;
            dma_req    <= (dma_req & ~dma_clr) | dma_set;
            case (state)
                SQ_IDLE: if (pick_hit) begin
                    cur_grp <= pick_idx;
                    seg     <= '0;
                    state   <= SQ_INIT;
                end
                SQ_INIT: if (tmr_zero) state <= SQ_REQ;
                SQ_REQ: if (conv_ack) begin
                    res_q[cur_grp][seg] <= conv_result;
                    if (last) state <= SQ_IDLE;
                    else begin
                        seg   <= seg + 1'b1;
                        state <= SQ_GAP;
                    end
                end
                default: if (tmr_zero) state <= SQ_REQ;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ack && !soft_rst) |=> (conv_req && $stable(conv_chan) && $stable(conv_slot))); // R6
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE && !soft_rst) |=> (state == SQ_IDLE || $stable(cur_grp))); // R2
    AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !(conv_req && conv_ack) |=> ((done_flags & ~$past(done_flags)) == '0)); // R8
    AST_DMA_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !(conv_req && conv_ack) |=> ((dma_req & ~$past(dma_req)) == '0)); // R9
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!conv_req && dma_req == '0 && err_flags == '0)); // R11
endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
    logic         clk = 0;
    logic         rst = 1, soft_rst = 0;
    logic [7:0]   hw_trig = 0, sw_trig = 0, sw_mode = 0, grp_b2b = 0;
    logic [23:0]  grp_prio = 0, grp_len = 0;
    logic [63:0]  grp_init_dly = 0, grp_intv = 0;
    logic [7:0]   prescale = 0, dma_en = 0, dma_clr = 0, stat_clr = 0;
    logic [511:0] seg_slot = 0;
    logic [319:0] seg_chan = 0;
    logic [127:0] seg_irq = 0;
    logic         conv_req, conv_ack = 0;
    logic [7:0]   conv_slot;
    logic [4:0]   conv_chan;
    logic [11:0]  conv_result = 0, rd_data;
    logic [2:0]   rd_grp = 0, rd_seg = 0;
    logic [23:0]  done_flags;
    logic [7:0]   err_flags, dma_req;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    adc_seq_top u_dut (.*);

    typedef struct packed { int g; int len; int idly; int pre; int b2b; int intv; } vec_t;
    localparam vec_t VECS [4] = '{
        '{1, 3, 4, 0, 0, 2},
        '{4, 1, 0, 2, 0, 0},
        '{7, 8, 2, 3, 1, 5},
        '{3, 4, 1, 1, 0, 3}
    };

    function automatic logic [7:0]  x_slot(int g, int s); return 8'(1 << ((g + s) % 8)); endfunction
    function automatic logic [4:0]  x_chan(int g, int s); return 5'((g * 4 + s) % 32); endfunction
    function automatic logic [1:0]  x_irq(int g, int s);  return 2'((g + s) % 4); endfunction
    function automatic logic [11:0] x_res(int g, int s);  return 12'(12'h400 + g * 16 + s + 1); endfunction
    function automatic logic [2:0]  x_done(int g, int len);
        logic [2:0] d = 0;
        for (int s = 0; s < len; s++) if (x_irq(g, s) != 0) d[x_irq(g, s) - 1] = 1'b1;
        return d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic fire(input logic [7:0] m);
        sw_trig = m;
        @(negedge clk) sw_trig = 0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk); conv_ack = 0;
        end while (!conv_req && n < 2000);
    endtask

    task automatic quiet(input int cyc, input string tag);
        int hits = 0;
        repeat (cyc) @(negedge clk) if (conv_req) hits++;
        chk(tag, hits, 0);
    endtask

    task automatic set_grp(input int g, input int len, input int idly, input int b2b, input int intv, input int pr);
        grp_len[g*3 +: 3]       = 3'(len - 1);
        grp_init_dly[g*8 +: 8]  = 8'(idly);
        grp_intv[g*8 +: 8]      = 8'(intv);
        grp_b2b[g]              = b2b[0];
        grp_prio[g*3 +: 3]      = 3'(pr);
    endtask

    task automatic run_chain(input int g, input int nseg, input int first, input int gap);
        int n;
        wait_req(n);
        if (first >= 0) chk("R4 start delay cycles", n, first);
        for (int s = 0; s < nseg; s++) begin
            chk("R6 slot", int'(conv_slot), int'(x_slot(g, s)));
            chk("R6 channel", int'(conv_chan), int'(x_chan(g, s)));
            conv_result = x_res(g, s);
            conv_ack = 1;
            if (s < nseg - 1) begin
                wait_req(n);
                if (gap >= 0) chk("R5 step spacing", n, gap);
            end else begin
                @(posedge clk); @(negedge clk); conv_ack = 0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        for (int g = 0; g < 8; g++)
            for (int s = 0; s < 8; s++) begin
                seg_slot[(g*8+s)*8 +: 8] = x_slot(g, s);
                seg_chan[(g*8+s)*5 +: 5] = x_chan(g, s);
                seg_irq[(g*8+s)*2 +: 2]  = x_irq(g, s);
            end
        sw_mode = 8'hFF;
        dma_en  = 8'hF7;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R12 reset state
        chk("R12 req idle", int'(conv_req), 0);
        chk("R12 done flags", int'(done_flags), 0);
        chk("R12 err flags", int'(err_flags), 0);
        chk("R12 dma flags", int'(dma_req), 0);
        #1 chk("R12 stored result", int'(rd_data), 0);

        // table of chains: R3 lengths, R4/R5 timing, R7 capture, R8 flags, R9 transfer
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            int fst = 2 + v.idly * (v.pre + 1);
            int gp  = v.b2b != 0 ? 2 : 2 + v.intv * (v.pre + 1);
            set_grp(v.g, v.len, v.idly, v.b2b, v.intv, 1);
            prescale = 8'(v.pre);
            @(negedge clk);
            fire(8'(1 << v.g));
            run_chain(v.g, v.len, fst, gp);
            quiet(3, "R3 no step past chain length");
            chk("R8 done flags", int'(done_flags[v.g*3 +: 3]), int'(x_done(v.g, v.len)));
            chk("R9 transfer gated by enable", int'(dma_req[v.g]), v.g != 3 ? 1 : 0);
            for (int s = 0; s < v.len; s++) begin
                rd_grp = 3'(v.g); rd_seg = 3'(s);
                #1 chk("R7 stored result", int'(rd_data), int'(x_res(v.g, s)));
                @(negedge clk);
            end
            stat_clr = 8'hFF; dma_clr = 8'hFF;
            @(negedge clk) stat_clr = 0; dma_clr = 0;
            chk("R9 write-1 clear", int'(dma_req), 0);
            chk("R8 status clear", int'(done_flags), 0);
        end

        // R2 arbitration and R10 collision
        prescale = 0;
        set_grp(0, 1, 30, 0, 0, 0);
        set_grp(2, 1, 0, 0, 0, 3);
        set_grp(5, 1, 0, 0, 0, 6);
        set_grp(6, 1, 0, 0, 0, 6);
        @(negedge clk);
        fire(8'h01);
        @(negedge clk);
        fire(8'h65);
        chk("R10 error flag on busy group", int'(err_flags[0]), 1);
        run_chain(0, 1, -1, -1);
        run_chain(5, 1, -1, -1);
        run_chain(6, 1, -1, -1);
        run_chain(2, 1, -1, -1);
        quiet(40, "R10 colliding trigger dropped");
        chk("R2 order checked by channel", int'(err_flags), 1);
        stat_clr = 8'hFF;
        @(negedge clk) stat_clr = 0;
        chk("R8 error cleared", int'(err_flags), 0);

        // R1 trigger sources
        set_grp(3, 1, 0, 0, 0, 1);
        sw_mode[3] = 0;
        @(negedge clk) hw_trig[3] = 1;
        repeat (3) @(negedge clk);
        hw_trig[3] = 0;
        run_chain(3, 1, -1, -1);
        quiet(20, "R1 held level queues once");
        fire(8'h08);
        quiet(20, "R1 software pulse ignored in hardware mode");
        sw_mode[3] = 1;
        @(negedge clk) hw_trig[3] = 1;
        @(negedge clk) hw_trig[3] = 0;
        quiet(20, "R1 hardware edge ignored in software mode");

        // R11 soft reset
        begin
            int n;
            fire(8'h10);
            wait_req(n);
            fire(8'h10);
            chk("R10 error before soft reset", int'(err_flags[4]), 1);
            soft_rst = 1;
            @(negedge clk);
            chk("R11 request dropped", int'(conv_req), 0);
            chk("R11 error flags cleared", int'(err_flags), 0);
            rd_grp = 3'd4; rd_seg = 3'd0;
            #1 chk("R11 stored results cleared", int'(rd_data), 0);
            fire(8'h10);
            soft_rst = 0;
            quiet(20, "R11 trigger ignored during soft reset");
        end
        summary();
    end
endmodule